// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the memory address sequence for one DMA work unit. Software loads six configuration values while the channel is off: a start address, a control word, an inner element count with its stride, and an outer row count with its stride. When the channel enable rises, the block presents one address per element on `addr` with `xfer_valid` high. The data path takes each element by raising `xfer_ack`.

Inside a row the address moves by the inner stride. When a row ends, the address moves by the outer stride instead, and the inner count reloads. When the last element of the last row is accepted, the job either stops and raises `done`, or reloads from the start address and repeats. The control word selects which.

When enabled, an interrupt status bit is set at the end of each job. Software clears it with a one-cycle `irq_clr` pulse. A restart option emits a one-cycle FIFO flush strobe when the channel is enabled.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `xfer_valid`, `done`, `irq` and `fifo_flush` are low, and `addr`, `x_left` and `y_left` are zero.
- R2: A write with `cfg_we` high loads a register chosen by `cfg_sel`: 0 start address, 1 control word, 2 inner count, 3 inner stride, 4 outer count, 5 outer stride. The write takes effect only while `chan_en` is low. While `chan_en` is high, writes are ignored.
- R3: On the clock edge where `chan_en` is first seen high, `addr` loads the start address, `x_left` loads the inner count and `y_left` loads the outer count. `xfer_valid` is high from the following cycle.
- R4: A clock edge with `xfer_valid` and `xfer_ack` both high consumes one element. Within a row, `addr` then advances by the sign-extended inner stride and `x_left` decrements. With `xfer_ack` low, `addr` and the counts hold.
- R5: When the last element of a row is consumed and rows remain, `addr` advances by the sign-extended outer stride instead of the inner stride. `x_left` then reloads the inner count and `y_left` decrements.
- R6: A count value of 0 means 2^CW elements or rows.
- R7: With control bit 3 clear (one-dimensional mode), the outer count and outer stride are ignored, and the job ends after the inner count of elements.
- R8: With control bits [5:4] = 00 (stop flow), `xfer_valid` falls after the last element and `done` rises. `done` stays high, including after the channel is disabled, until the next enable.
- R9: With control bits [5:4] = 01 (repeat flow), the end of a job reloads `addr` and both counts from the registers. The job repeats while `chan_en` stays high, and `done` stays low.
- R10: With control bit 2 set, the end of every job sets `irq`. A cycle with `irq_clr` high clears it. If a set and a clear fall in the same cycle, the set wins. With bit 2 clear, `irq` stays low.
- R11: With control bit 1 set, `fifo_flush` is high for exactly the one cycle after the enabling edge. With bit 1 clear, `fifo_flush` never pulses.
- R12: `dir_wr` equals control bit 0 (1 means writes to memory).
- R13: While `chan_en` is low, `xfer_valid` is low, and no element is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | AW | Register write data |
| chan_en | input | 1 | Channel enable |
| xfer_ack | input | 1 | Data path accepts the current element |
| irq_clr | input | 1 | Clears interrupt status |
| addr | output | AW | Current element address |
| xfer_valid | output | 1 | Element address is valid |
| dir_wr | output | 1 | Transfer direction, 1 = write to memory |
| fifo_flush | output | 1 | One-cycle FIFO discard strobe |
| irq | output | 1 | Interrupt status |
| done | output | 1 | Stop-flow job finished |
| x_left | output | CW | Elements left in the current row |
| y_left | output | CW | Rows left, including the current one |

## Verification
The bench builds the block with AW=16, CW=3 and SW=8. With a 3-bit count, the bench can sweep every inner and outer count from 0 to 7. Code 0 is the 2^CW case, so a full eight-by-eight grid of jobs covers the zero-means-maximum rule and every row-boundary position.

The strides alternate between positive and negative values, so sign extension and 16-bit address wrap are both exercised. A job is at most 64 elements long, which keeps repeat-flow passes, stalls and interrupt clearing short enough to check element by element.

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          chan_en,
  input  logic          xfer_ack,
  input  logic          irq_clr,
  output logic [AW-1:0] addr,
  output logic          xfer_valid,
  output logic          dir_wr,
  output logic          fifo_flush,
  output logic          irq,
  output logic          done,
  output logic [CW-1:0] x_left,
  output logic [CW-1:0] y_left
);
  localparam logic [1:0] FLOW_REPEAT = 2'b01;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [AW-1:0] start_q;
  logic [5:0]    ctl_q;
  logic [CW-1:0] xcnt_q, ycnt_q;
  logic [SW-1:0] xstr_q, ystr_q;
  logic          en_q, active_q, done_q, irq_q, flush_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] xl_q, yl_q;

  wire go       = chan_en & ~en_q;
  wire step     = active_q & chan_en & xfer_ack;
  wire row_end  = (xl_q == ONE);
  wire job_end  = row_end & (yl_q == ONE);
  wire two_d    = ctl_q[3];
  wire repeat_f = (ctl_q[5:4] == FLOW_REPEAT);
  wire [CW-1:0] ycnt_eff = two_d ? ycnt_q : ONE;
  wire [AW-1:0] xinc = {{(AW-SW){xstr_q[SW-1]}}, xstr_q};
  wire [AW-1:0] yinc = {{(AW-SW){ystr_q[SW-1]}}, ystr_q};

  assign addr       = addr_q;
  assign xfer_valid = active_q & chan_en;
  assign dir_wr     = ctl_q[0];
  assign fifo_flush = flush_q;
  assign irq        = irq_q;
  assign done       = done_q;
  assign x_left     = xl_q;
  assign y_left     = yl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= '0;
      ctl_q    <= '0;
      xcnt_q   <= '0;
      ycnt_q   <= '0;
      xstr_q   <= '0;
      ystr_q   <= '0;
      en_q     <= 1'b0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      irq_q    <= 1'b0;
      flush_q  <= 1'b0;
      addr_q   <= '0;
      xl_q     <= '0;
      yl_q     <= '0;
    end else begin
      en_q    <= chan_en;
      flush_q <= go & ctl_q[1];

      if (cfg_we && !chan_en) begin
        case (cfg_sel)
          3'd0: start_q <= cfg_wdata;
          3'd1: ctl_q   <= cfg_wdata[5:0];
          3'd2: xcnt_q  <= cfg_wdata[CW-1:0];
          3'd3: xstr_q  <= cfg_wdata[SW-1:0];
          3'd4: ycnt_q  <= cfg_wdata[CW-1:0];
          3'd5: ystr_q  <= cfg_wdata[SW-1:0];
          default: ;
        endcase
      end

      if (go) begin
        addr_q   <= start_q;
        xl_q     <= xcnt_q;
        yl_q     <= ycnt_eff;
        active_q <= 1'b1;
        done_q   <= 1'b0;
      end else if (!chan_en) begin
        active_q <= 1'b0;
      end else if (step) begin
        if (job_end) begin
          if (repeat_f) begin
            addr_q <= start_q;
            xl_q   <= xcnt_q;
            yl_q   <= ycnt_eff;
          end else begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end
        end else if (row_end) begin
          addr_q <= addr_q + yinc;
          xl_q   <= xcnt_q;
          yl_q   <= yl_q - ONE;
        end else begin
          addr_q <= addr_q + xinc;
          xl_q   <= xl_q - ONE;
        end
      end

      if (step && job_end && ctl_q[2]) irq_q <= 1'b1;
      else if (irq_clr)                irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dma2d_addr_gen_sva.sv
module dma2d_addr_gen_sva #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chan_en,
  input logic          xfer_ack,
  input logic          irq_clr,
  input logic [AW-1:0] addr,
  input logic          xfer_valid,
  input logic          fifo_flush,
  input logic          irq,
  input logic          done,
  input logic [AW-1:0] start_q
);
  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ack) |=> $stable(addr));

  assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en |=> $stable(start_q));

  assert_first_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_en) |=> (addr == $past(start_q)));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !xfer_valid);

  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(irq_clr));

  assert_flush_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> !fifo_flush);

  assert_off_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> !xfer_valid);
endmodule

bind dma2d_addr_gen dma2d_addr_gen_sva #(.AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .xfer_ack(xfer_ack),
  .irq_clr(irq_clr), .addr(addr), .xfer_valid(xfer_valid),
  .fifo_flush(fifo_flush), .irq(irq), .done(done), .start_q(start_q)
);

// File: tb/dma2d_addr_gen_tb.sv
module dma2d_addr_gen_tb;
  localparam int AW = 16;
  localparam int CW = 3;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic chan_en = 1'b0, xfer_ack = 1'b0, irq_clr = 1'b0;
  logic [AW-1:0] addr;
  logic xfer_valid, dir_wr, fifo_flush, irq, done;
  logic [CW-1:0] x_left, y_left;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  dma2d_addr_gen #(.AW(AW), .CW(CW), .SW(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .chan_en(chan_en), .xfer_ack(xfer_ack),
    .irq_clr(irq_clr), .addr(addr), .xfer_valid(xfer_valid),
    .dir_wr(dir_wr), .fifo_flush(fifo_flush), .irq(irq), .done(done),
    .x_left(x_left), .y_left(y_left)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [AW-1:0] st, input logic [5:0] ctl,
                       input int xc, input logic [SW-1:0] xm,
                       input int yc, input logic [SW-1:0] ym);
    wr(3'd0, st);
    wr(3'd1, AW'(ctl));
    wr(3'd2, AW'(xc));
    wr(3'd3, AW'(xm));
    wr(3'd4, AW'(yc));
    wr(3'd5, AW'(ym));
  endtask

  function automatic logic [AW-1:0] sx(input logic [SW-1:0] s);
    return {{(AW-SW){s[SW-1]}}, s};
  endfunction

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] st, input int xn,
      input logic [SW-1:0] xm, input logic [SW-1:0] ym, input int r, input int c);
    logic [AW-1:0] a;
    a = st;
    for (int i = 0; i < r; i++) a = a + AW'(xn - 1) * sx(xm) + sx(ym);
    for (int j = 0; j < c; j++) a = a + sx(xm);
    return a;
  endfunction

  task automatic run_stop(input logic [AW-1:0] st, input bit twod, input int xc,
      input logic [SW-1:0] xm, input int yc, input logic [SW-1:0] ym);
    int xn, yn;
    logic [AW-1:0] e;
    setup(st, {2'b00, twod, 1'b1, 1'b0, 1'b0}, xc, xm, yc, ym);
    xn = (xc == 0) ? 8 : xc;
    yn = twod ? ((yc == 0) ? 8 : yc) : 1;
    @(negedge clk);
    chan_en = 1'b1; xfer_ack = 1'b1;
    for (int r = 0; r < yn; r++) begin
      for (int c = 0; c < xn; c++) begin
        @(negedge clk);
        e = exp_addr(st, xn, xm, ym, r, c);
        if (r == 0 && c == 0) begin
          chk(x_left == CW'(xc), "R3/R6 x_left load", x_left, xc);
          chk(y_left == (twod ? CW'(yc) : CW'(1)), "R3/R7 y_left load", y_left, twod ? yc : 1);
        end
        chk(xfer_valid && addr == e, twod ? "R4/R5 addr sweep" : "R7 addr 1d", addr, e);
      end
    end
    @(negedge clk);
    chk(!xfer_valid && done, "R8 stop at end", {xfer_valid, done}, 1);
    chk(irq, "R10 irq set", irq, 1);
    irq_clr = 1'b1; chan_en = 1'b0;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(!irq, "R10 irq cleared", irq, 0);
    chk(done, "R8 done held", done, 1);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [AW-1:0] e;
    #1;
    chk(!xfer_valid && !done && !irq && !fifo_flush && addr == 0 && x_left == 0 && y_left == 0,
        "R1 reset state", addr, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int xc = 0; xc < 8; xc++)
      for (int yc = 0; yc < 8; yc++)
        run_stop(AW'(16'h1000 + xc * 37 + yc), 1'b1, xc,
                 (yc[0] ? 8'd3 : 8'hFE), yc, (xc[0] ? 8'd5 : 8'hF9));

    // R7: 1-D ignores outer count/stride
    run_stop(16'h0040, 1'b0, 5, 8'd2, 6, 8'd100);
    run_stop(16'h0002, 1'b0, 0, 8'hFF, 3, 8'd9);

    // R12, R11 with restart set, dir bit set, irq disabled
    setup(16'h0200, 6'b001011, 3, 8'd1, 1, 8'd1);
    chk(dir_wr, "R12 dir_wr", dir_wr, 1);
    @(negedge clk);
    chan_en = 1'b1; xfer_ack = 1'b0;
    @(negedge clk);
    chk(fifo_flush, "R11 flush pulse", fifo_flush, 1);
    // R4 stall holds
    repeat (3) begin
      @(negedge clk);
      chk(addr == 16'h0200 && x_left == 3, "R4 stall hold", addr, 16'h0200);
    end
    chk(!fifo_flush, "R11 single pulse", fifo_flush, 0);
    // R2: write while enabled ignored
    cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 16'h7777;
    @(negedge clk);
    cfg_we = 1'b0;
    xfer_ack = 1'b1;
    repeat (3) @(negedge clk);
    chk(done && !irq, "R10 irq masked", irq, 0);
    chan_en = 1'b0;
    @(negedge clk);
    chan_en = 1'b1;
    @(negedge clk);
    chk(addr == 16'h0200, "R2 write ignored", addr, 16'h0200);
    chk(!done, "R8 done clears on enable", done, 0);
    chan_en = 1'b0;
    @(negedge clk);

    // R11 no flush without restart bit; R9 repeat flow
    setup(16'h0300, 6'b011100, 2, 8'd4, 2, 8'd16);
    chk(!dir_wr, "R12 dir_wr low", dir_wr, 0);
    @(negedge clk);
    chan_en = 1'b1; xfer_ack = 1'b1;
    for (int p = 0; p < 3; p++)
      for (int r = 0; r < 2; r++)
        for (int c = 0; c < 2; c++) begin
          @(negedge clk);
          if (p == 0 && r == 0 && c == 0) chk(!fifo_flush, "R11 no flush", fifo_flush, 0);
          e = exp_addr(16'h0300, 2, 8'd4, 8'd16, r, c);
          chk(xfer_valid && addr == e && !done, "R9 repeat addr", addr, e);
          if (p == 1 && r == 0 && c == 0) chk(irq, "R9/R10 irq per pass", irq, 1);
        end
    chan_en = 1'b0;
    #1;
    chk(!xfer_valid, "R13 valid drops", xfer_valid, 0);
    e = addr;
    repeat (3) @(negedge clk);
    chk(addr == e && !xfer_valid && !done, "R13 no step when off", addr, e);

    // R10 set wins over clear
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    setup(16'h0010, 6'b000100, 1, 8'd1, 1, 8'd1);
    @(negedge clk);
    chan_en = 1'b1; xfer_ack = 1'b1;
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(irq && done, "R10 set wins", irq, 1);
    chan_en = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule